// File: doc/BRIEF.md
# Slow-Bus Peripheral Slave Port

This block lets logic running on a fast local clock appear as a memory-mapped peripheral on a slow 8-bit microprocessor bus whose clock is unrelated to the local one. Every bus input is brought into the local domain through two-flop synchronizers. A bus access is recognised when the active-high select is high and the active-low select is low at the same time, and it is served only while the bus clock is high. The read/write line chooses between a read handler and a write handler.

CPU reads are answered from a 256-byte shadow array. The local side fills the array through its own write port. The byte for the addressed location is latched when the read is accepted and driven with the output enable until the bus clock falls. If a local write and the read capture hit the same location in the same cycle, the read returns the old byte. CPU writes are posted into an event queue as address/data pairs, and a one-cycle write pulse is raised. Nothing waits on the consumer. A write to address 0xFF also raises a separate mode-switch pulse.

The controller is a four-state machine. IDLE waits for select with the bus clock high. Inside IDLE, select seen while the clock is low means "keep waiting". IDLE goes to READ when the read/write line is high and to WRITE when it is low. READ drives the bus and goes back to IDLE once the synchronized bus clock is low. WRITE lasts one cycle, pushes the queue entry and goes to HOLD. HOLD waits for the bus clock to go low and then goes to IDLE, so a long clock-high phase cannot produce a second event.

Top module: `sbus_periph`

## Requirements
- R1: After reset, data_oe_o, evt_valid_o, wr_evt_o, mode_evt_o and ovf_o are all low.
- R2: An access is accepted only when cs_hi_i is 1 and cs_lo_i is 0. With any other combination, no data is driven and no event is produced.
- R3: While bus_clk_i is low, a selected access is not served. It is served once bus_clk_i goes high with select still present.
- R4: A CPU write (rw_i = 0) produces exactly one wr_evt_o pulse per bus-clock high phase, however long that phase lasts.
- R5: A CPU read (rw_i = 1) asserts data_oe_o and drives data_o with the shadow byte. data_oe_o falls within 4 local cycles after bus_clk_i goes low.
- R6: A CPU write to address 0xFF raises one mode_evt_o pulse as well as the normal write event. Writes to other addresses raise none. A read of 0xFF returns the byte held at 0xFF.
- R7: A local write (loc_we_i with loc_addr_i and loc_wdata_i) updates the shadow array, and later CPU reads of that address return the new byte.
- R8: When the queue is full, a further CPU write is dropped and ovf_o is set. ovf_o stays set until a one-cycle ovf_clr_i pulse.
- R9: Queue entries appear on evt_addr_o/evt_data_o with evt_valid_o, in bus order. Each evt_pop_i cycle removes one entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_clk_i | input | 1 | Bus clock, asynchronous |
| cs_hi_i | input | 1 | Active-high select |
| cs_lo_i | input | 1 | Active-low select |
| rw_i | input | 1 | 1 = CPU read, 0 = CPU write |
| addr_i | input | 8 | Bus address |
| data_i | input | 8 | Bus data in |
| data_o | output | 8 | Bus data out |
| data_oe_o | output | 1 | Bus data output enable |
| loc_we_i | input | 1 | Local shadow write strobe |
| loc_addr_i | input | 8 | Local shadow address |
| loc_wdata_i | input | 8 | Local shadow data |
| evt_valid_o | output | 1 | Queue holds an entry |
| evt_addr_o | output | 8 | Address of head entry |
| evt_data_o | output | 8 | Data of head entry |
| evt_pop_i | input | 1 | Remove head entry |
| wr_evt_o | output | 1 | CPU write pulse |
| mode_evt_o | output | 1 | Write to 0xFF pulse |
| ovf_o | output | 1 | Sticky queue overflow |
| ovf_clr_i | input | 1 | Clear overflow |

## Verification
Suppose the state machine is stuck in READ or HOLD. Then data_oe_o stays high past the bus clock falling edge, or the next access gets no response. Either shows at the ports within a few local cycles of the next bus phase. A state that leaves WRITE more than once per phase shows as an extra wr_evt_o pulse and an unexpected queue entry, which the scoreboard flags when it pops that entry. Wrong queue pointers show as entries out of order or with wrong contents, or as an overflow flag raised too early or too late.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_HOLD  = 2'd3
    } bus_st_e;
endpackage

// File: rtl/sbus_sync.sv
module sbus_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1, s2;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
            end else begin
                s1 <= d_i[i];
                s2 <= s1;
            end
        end
        assign q_o[i] = s2;
    end
endmodule

// File: rtl/sbus_shadow.sv
module sbus_shadow #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    localparam int N = 1 << AW;
    logic [DW-1:0] mem [N];

    always_ff @(posedge clk) begin
        if (we_i) mem[waddr_i] <= wdata_i;
    end

    assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/sbus_evq.sv
module sbus_evq #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] din_i,
    input  logic         pop_i,
    output logic [W-1:0] dout_o,
    output logic         valid_o,
    output logic         full_o
);
    localparam int PW = $clog2(DEPTH);
    logic [W-1:0] mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [PW:0]   cnt;
    logic          do_push, do_pop;

    assign full_o  = (cnt == DEPTH[PW:0]);
    assign valid_o = (cnt != '0);
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && valid_o;
    assign dout_o  = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            cnt <= cnt + (do_push ? 1'b1 : 1'b0) - (do_pop ? 1'b1 : 1'b0);
        end
    end

    a_r8_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= DEPTH[PW:0]);
    a_r9_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !full_o && !pop_i) |=> valid_o);
endmodule

// File: rtl/sbus_periph.sv
module sbus_periph
    import sbus_pkg::*;
#(
    parameter int AW     = 8,
    parameter int DW     = 8,
    parameter int QDEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_clk_i,
    input  logic          cs_hi_i,
    input  logic          cs_lo_i,
    input  logic          rw_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] data_i,
    output logic [DW-1:0] data_o,
    output logic          data_oe_o,
    input  logic          loc_we_i,
    input  logic [AW-1:0] loc_addr_i,
    input  logic [DW-1:0] loc_wdata_i,
    output logic          evt_valid_o,
    output logic [AW-1:0] evt_addr_o,
    output logic [DW-1:0] evt_data_o,
    input  logic          evt_pop_i,
    output logic          wr_evt_o,
    output logic          mode_evt_o,
    output logic          ovf_o,
    input  logic          ovf_clr_i
);
    localparam int SW = 4 + AW + DW;
    localparam int EW = AW + DW;
    localparam logic [AW-1:0] MODE_ADDR = '1;

    logic [SW-1:0] raw_s, syn_s;
    logic          clk_s, cshi_s, cslo_s, rw_s, sel;
    logic [AW-1:0] addr_s;
    logic [DW-1:0] data_s;
    logic [DW-1:0] sh_rdata;
    logic [AW-1:0] cap_addr;
    logic [DW-1:0] cap_data;
    logic          q_full, push;
    logic [EW-1:0] q_dout;
    bus_st_e       state, nxt;

    assign raw_s = {bus_clk_i, cs_hi_i, cs_lo_i, rw_i, addr_i, data_i};

    sbus_sync #(.W(SW)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(raw_s), .q_o(syn_s)
    );

    assign {clk_s, cshi_s, cslo_s, rw_s, addr_s, data_s} = syn_s;
    assign sel = cshi_s && !cslo_s;

    sbus_shadow #(.AW(AW), .DW(DW)) u_shadow (
        .clk(clk), .we_i(loc_we_i), .waddr_i(loc_addr_i),
        .wdata_i(loc_wdata_i), .raddr_i(addr_s), .rdata_o(sh_rdata)
    );

    assign push = (state == ST_WRITE);

    sbus_evq #(.W(EW), .DEPTH(QDEPTH)) u_evq (
        .clk(clk), .rst_n(rst_n), .push_i(push), .din_i({cap_addr, cap_data}),
        .pop_i(evt_pop_i), .dout_o(q_dout), .valid_o(evt_valid_o), .full_o(q_full)
    );

    assign {evt_addr_o, evt_data_o} = q_dout;

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (sel && clk_s) nxt = rw_s ? ST_READ : ST_WRITE;
            ST_READ:  if (!clk_s) nxt = ST_IDLE;
            ST_WRITE: nxt = ST_HOLD;
            ST_HOLD:  if (!clk_s) nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_o     <= '0;
            data_oe_o  <= 1'b0;
            cap_addr   <= '0;
            cap_data   <= '0;
            wr_evt_o   <= 1'b0;
            mode_evt_o <= 1'b0;
            ovf_o      <= 1'b0;
        end else begin
            data_oe_o  <= (nxt == ST_READ);
            wr_evt_o   <= push;
            mode_evt_o <= push && (cap_addr == MODE_ADDR);
            if (state == ST_IDLE && nxt == ST_READ) data_o <= sh_rdata;
            if (state == ST_IDLE && nxt == ST_WRITE) begin
                cap_addr <= addr_s;
                cap_data <= data_s;
            end
            if (push && q_full)  ovf_o <= 1'b1;
            else if (ovf_clr_i)  ovf_o <= 1'b0;
        end
    end

    a_r4_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_evt_o |=> !wr_evt_o);
    a_r6_mode_with_write: assert property (@(posedge clk) disable iff (!rst_n)
        mode_evt_o |-> wr_evt_o);
    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !ovf_clr_i) |=> ovf_o);
    a_r5_oe_not_write: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe_o |-> !wr_evt_o);
    a_r5_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe_o && $past(data_oe_o)) |-> $stable(data_o));
endmodule

// File: tb/sbus_periph_bench.sv
module sbus_periph_bench;
    logic clk = 0, rst_n = 0;
    logic bus_clk = 0, cs_hi = 0, cs_lo = 1, rw = 1;
    logic [7:0] addr = 0, din = 0, dout;
    logic oe, loc_we = 0, evt_valid, evt_pop = 0, wr_evt, mode_evt, ovf, ovf_clr = 0;
    logic [7:0] loc_addr = 0, loc_wdata = 0, evt_addr, evt_data;
    int checks = 0, errors = 0, wr_seen = 0, mode_seen = 0;
    logic hold_pop = 0;
    logic [15:0] expq [$];

    always #4 clk = ~clk;

    sbus_periph u_sbus_periph (
        .clk(clk), .rst_n(rst_n), .bus_clk_i(bus_clk), .cs_hi_i(cs_hi), .cs_lo_i(cs_lo),
        .rw_i(rw), .addr_i(addr), .data_i(din), .data_o(dout), .data_oe_o(oe),
        .loc_we_i(loc_we), .loc_addr_i(loc_addr), .loc_wdata_i(loc_wdata),
        .evt_valid_o(evt_valid), .evt_addr_o(evt_addr), .evt_data_o(evt_data),
        .evt_pop_i(evt_pop), .wr_evt_o(wr_evt), .mode_evt_o(mode_evt),
        .ovf_o(ovf), .ovf_clr_i(ovf_clr)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pulse counting and scoreboard pops
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_evt) wr_seen++;
            if (mode_evt) mode_seen++;
            evt_pop <= 1'b0;
            if (!hold_pop && evt_valid && !evt_pop) begin
                if (expq.size() == 0) chk(0, "R9 unexpected entry", {evt_addr, evt_data}, 0);
                else begin
                    logic [15:0] e;
                    e = expq.pop_front();
                    chk({evt_addr, evt_data} == e, "R9 queue entry", {evt_addr, evt_data}, e);
                end
                evt_pop <= 1'b1;
            end
        end
    end

    task automatic loc_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        loc_we = 1; loc_addr = a; loc_wdata = d;
        @(negedge clk);
        loc_we = 0;
    endtask

    // driver: one bus phase; returns data seen while clock high and oe after fall
    task automatic bus_cyc(input logic rd, input logic [7:0] a, input logic [7:0] d,
                           input logic h, input logic l, input logic expect_q,
                           output logic [7:0] rv, output logic oe_hi, output logic oe_after);
        @(negedge clk);
        rw = rd; addr = a; din = d; cs_hi = h; cs_lo = l;
        repeat (4) @(negedge clk);
        bus_clk = 1;
        if (!rd && h && !l && expect_q) expq.push_back({a, d});
        repeat (10) @(negedge clk);
        rv = dout; oe_hi = oe;
        bus_clk = 0;
        repeat (4) @(negedge clk);
        oe_after = oe;
        cs_hi = 0; cs_lo = 1;
        repeat (3) @(negedge clk);
    endtask

    logic [7:0] rv;
    logic oh, oa;
    int w0, m0;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!oe && !evt_valid && !ovf && !wr_evt && !mode_evt, "R1 reset state",
            {oe, evt_valid, ovf, wr_evt, mode_evt}, 0);

        loc_write(8'h10, 8'hA5);
        loc_write(8'h20, 8'h3C);
        loc_write(8'hFF, 8'h77);

        bus_cyc(1, 8'h10, 0, 1, 0, 0, rv, oh, oa);
        chk(oh && rv == 8'hA5, "R7 read after local write", rv, 8'hA5);
        chk(oh, "R5 oe during read", oh, 1);
        chk(!oa, "R5 oe released after clock low", oa, 0);
        bus_cyc(1, 8'h20, 0, 1, 0, 0, rv, oh, oa);
        chk(rv == 8'h3C, "R5 read second byte", rv, 8'h3C);

        loc_write(8'h10, 8'h5A);
        bus_cyc(1, 8'h10, 0, 1, 0, 0, rv, oh, oa);
        chk(rv == 8'h5A, "R7 overwritten byte", rv, 8'h5A);

        w0 = wr_seen;
        bus_cyc(1, 8'h10, 0, 0, 0, 0, rv, oh, oa);
        chk(!oh, "R2 cs_hi low no drive", oh, 0);
        bus_cyc(0, 8'h30, 8'h44, 1, 1, 0, rv, oh, oa);
        chk(wr_seen == w0 && !evt_valid, "R2 cs_lo high no write", wr_seen - w0, 0);

        // R3: select with bus clock low is not served
        @(negedge clk);
        rw = 1; addr = 8'h20; cs_hi = 1; cs_lo = 0;
        repeat (10) @(negedge clk);
        chk(!oe, "R3 no drive while clock low", oe, 0);
        bus_clk = 1;
        repeat (6) @(negedge clk);
        chk(oe && dout == 8'h3C, "R3 served once clock high", dout, 8'h3C);
        bus_clk = 0; cs_hi = 0; cs_lo = 1;
        repeat (6) @(negedge clk);

        w0 = wr_seen; m0 = mode_seen;
        bus_cyc(0, 8'h05, 8'h11, 1, 0, 1, rv, oh, oa);
        bus_cyc(0, 8'h06, 8'h22, 1, 0, 1, rv, oh, oa);
        chk(wr_seen - w0 == 2, "R4 one pulse per phase", wr_seen - w0, 2);
        chk(mode_seen == m0, "R6 no mode pulse on normal address", mode_seen - m0, 0);
        bus_cyc(0, 8'hFE, 8'h12, 1, 0, 1, rv, oh, oa);
        chk(mode_seen == m0, "R6 no mode pulse at 0xFE", mode_seen - m0, 0);
        bus_cyc(0, 8'hFF, 8'h99, 1, 0, 1, rv, oh, oa);
        chk(mode_seen - m0 == 1, "R6 mode pulse at 0xFF", mode_seen - m0, 1);
        chk(wr_seen - w0 == 4, "R6 write event with mode pulse", wr_seen - w0, 4);
        bus_cyc(1, 8'hFF, 0, 1, 0, 0, rv, oh, oa);
        chk(rv == 8'h77, "R6 read of 0xFF returns held byte", rv, 8'h77);
        repeat (4) @(negedge clk);
        chk(expq.size() == 0 && !evt_valid, "R9 queue drained", expq.size(), 0);

        // R8: overflow
        hold_pop = 1;
        for (int i = 0; i < 5; i++)
            bus_cyc(0, 8'h40 + 8'(i), 8'h80 + 8'(i), 1, 0, i < 4, rv, oh, oa);
        chk(ovf, "R8 overflow set when full", ovf, 1);
        repeat (5) @(negedge clk);
        chk(ovf, "R8 overflow sticky", ovf, 1);
        ovf_clr = 1;
        @(negedge clk);
        ovf_clr = 0;
        @(negedge clk);
        chk(!ovf, "R8 overflow cleared", ovf, 0);
        hold_pop = 0;
        repeat (12) @(negedge clk);
        chk(expq.size() == 0 && !evt_valid, "R8 dropped entry absent", expq.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule